// File: doc/BRIEF.md
# Keypad Scan Code Command Decoder

This block listens to a keyboard on its two open-collector lines (clock and data) and turns key presses into 4-bit commands for a field-measurement controller. The keyboard clock is brought into the system clock domain through a two-flop synchronizer. Data is sampled on each falling edge, and the eight code bits of every 11-bit frame are collected. Once a frame is complete, the code is handed to a translator together with a one-cycle transfer strobe.

The translator turns a small set of numeric-keypad keys into axis-toggle, range-select and zero-reference commands. Every other code becomes the all-ones vector. The release prefix is absorbed, and so is the code of the key that was released. Each axis toggle fires once per press: held-key auto-repeat cannot flip an axis back and forth. A partial frame that stalls for longer than a configurable idle time is thrown away, so the next frame starts clean.

Top module: `keypadCmdDecoder`

## Requirements
- R1: After reset, `cmdValid` is low and `cmdCode` is 4'hF.
- R2: A frame is 11 bits on falling keyboard-clock edges: a start bit, eight code bits least significant first, a parity bit and a stop bit. Only the eight code bits are used. Parity and stop values are not checked and do not affect the result.
- R3: Each completed frame produces at most one command, signalled by `cmdValid` high for exactly one system clock.
- R4: Keypad 1 (8'h69) gives 4'd3, keypad 2 (8'h72) gives 4'd4, keypad 3 (8'h7A) gives 4'd5 and keypad 0 (8'h70) gives 4'd6. These select ranges of 10, 30, 100 and 300 V/m. Keypad point (8'h71) gives 4'd7 (step to the next higher range), and keypad minus (8'h7B) gives 4'd8 (zero the probe).
- R5: Keypad 7 (8'h6C), 8 (8'h75) and 9 (8'h7D) give 4'd0, 4'd1 and 4'd2, which toggle the X, Y and Z axis enables.
- R6: Any other code except 8'hF0 produces a command of 4'hF.
- R7: The byte 8'hF0 produces no command, and neither does the single code that follows it. The code after that is decoded normally.
- R8: After an axis toggle fires, further make codes of that same key produce no command until that key's release (8'hF0 and then its code) has been received. The three axes are armed independently.
- R9: Range, step and zero keys produce their command on every make code, including repeats.
- R10: If no falling keyboard-clock edge arrives for `TIMEOUT_CYC` system clocks in the middle of a frame, the partial frame is discarded. The next falling edge is then taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| kbClk | input | 1 | Keyboard clock line, asynchronous |
| kbData | input | 1 | Keyboard data line, asynchronous |
| cmdValid | output | 1 | One-cycle strobe for a new command |
| cmdCode | output | 4 | Command vector, meaningful when `cmdValid` is high |

## Verification
A bit counter that slips shows up within one frame: the command for the next key comes out as a shifted code, which usually means a wrong range or 4'hF. A break flag left set swallows the next valid key, and a flag that fails to set lets a released key emit a command. Either fault is visible on the very next frame. A stuck axis-armed bit shows only on the next press of that same axis key, so the sweeps repeat toggle presses with and without an intervening release.

// File: rtl/kbdCmdPkg.sv
package kbdCmdPkg;
  localparam int FRAME_BITS = 11;
  localparam int CODE_BITS  = 8;
  localparam int CMD_W      = 4;
  localparam int NUM_AXES   = 3;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic shiftBit;
    logic codeReady;
  } frameStrobes_t;

  localparam logic [CODE_BITS-1:0] SC_BREAK = 8'hF0;

  localparam logic [CMD_W-1:0] CMD_TOG_X    = 4'd0;
  localparam logic [CMD_W-1:0] CMD_TOG_Y    = 4'd1;
  localparam logic [CMD_W-1:0] CMD_TOG_Z    = 4'd2;
  localparam logic [CMD_W-1:0] CMD_RNG_10   = 4'd3;
  localparam logic [CMD_W-1:0] CMD_RNG_30   = 4'd4;
  localparam logic [CMD_W-1:0] CMD_RNG_100  = 4'd5;
  localparam logic [CMD_W-1:0] CMD_RNG_300  = 4'd6;
  localparam logic [CMD_W-1:0] CMD_RNG_NEXT = 4'd7;
  localparam logic [CMD_W-1:0] CMD_ZERO     = 4'd8;
  localparam logic [CMD_W-1:0] CMD_NONE     = 4'hF;

  function automatic logic [CMD_W-1:0] scanToCmd(input logic [CODE_BITS-1:0] sc);
    logic [CMD_W-1:0] res;
    case (sc)
      8'h6C:   res = CMD_TOG_X;
      8'h75:   res = CMD_TOG_Y;
      8'h7D:   res = CMD_TOG_Z;
      8'h69:   res = CMD_RNG_10;
      8'h72:   res = CMD_RNG_30;
      8'h7A:   res = CMD_RNG_100;
      8'h70:   res = CMD_RNG_300;
      8'h71:   res = CMD_RNG_NEXT;
      8'h7B:   res = CMD_ZERO;
      default: res = CMD_NONE;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/kbdLineData.sv
module kbdLineData
  import kbdCmdPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 kbClk,
  input  logic                 kbData,
  input  frameStrobes_t        strobes,
  output logic                 fallEdge,
  output logic                 gotCode,
  output logic [CODE_BITS-1:0] scanCode
);
  logic [2:0]           clkSync;
  logic [1:0]           dataSync;
  logic [CODE_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '1;
      dataSync <= '1;
    end else begin
      clkSync  <= {clkSync[1:0], kbClk};
      dataSync <= {dataSync[0], kbData};
    end
  end

  assign fallEdge = clkSync[2] & ~clkSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      scanCode <= '0;
      gotCode  <= 1'b0;
    end else begin
      if (strobes.shiftBit) shiftReg <= {dataSync[1], shiftReg[CODE_BITS-1:1]};
      if (strobes.codeReady) scanCode <= shiftReg;
      gotCode <= strobes.codeReady;
    end
  end
endmodule

// File: rtl/kbdFrameCtrl.sv
module kbdFrameCtrl
  import kbdCmdPkg::*;
#(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fallEdge,
  output frameStrobes_t strobes
);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(CODE_BITS);
  localparam logic [IDLE_W-1:0] IDLE_LIMIT = IDLE_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;

  always_comb begin
    strobes.shiftBit  = fallEdge && (bitCnt >= FIRST_DATA) && (bitCnt <= LAST_DATA);
    strobes.codeReady = fallEdge && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      idleCnt <= '0;
    end else if (fallEdge) begin
      idleCnt <= '0;
      bitCnt  <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end else if (bitCnt != '0) begin
      if (idleCnt == IDLE_LIMIT) begin
        bitCnt  <= '0;
        idleCnt <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end else begin
      idleCnt <= '0;
    end
  end
endmodule

// File: rtl/kbdCmdMap.sv
module kbdCmdMap
  import kbdCmdPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 gotCode,
  input  logic [CODE_BITS-1:0] scanCode,
  output logic                 cmdValid,
  output logic [CMD_W-1:0]     cmdCode
);
  logic                breakFlag;
  logic [NUM_AXES-1:0] armed;
  logic [CMD_W-1:0]    mapped;
  logic                isToggle;
  logic [1:0]          axisIdx;

  assign mapped   = scanToCmd(scanCode);
  assign isToggle = mapped < CMD_W'(NUM_AXES);
  assign axisIdx  = mapped[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakFlag <= 1'b0;
      armed     <= '1;
      cmdValid  <= 1'b0;
      cmdCode   <= CMD_NONE;
    end else begin
      cmdValid <= 1'b0;
      if (gotCode) begin
        if (scanCode == SC_BREAK) begin
          breakFlag <= 1'b1;
        end else if (breakFlag) begin
          breakFlag <= 1'b0;
          if (isToggle) armed[axisIdx] <= 1'b1;
        end else if (isToggle) begin
          if (armed[axisIdx]) begin
            armed[axisIdx] <= 1'b0;
            cmdValid       <= 1'b1;
            cmdCode        <= mapped;
          end
        end else begin
          cmdValid <= 1'b1;
          cmdCode  <= mapped;
        end
      end
    end
  end
endmodule

// File: rtl/keypadCmdDecoder.sv
module keypadCmdDecoder
  import kbdCmdPkg::*;
#(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kbClk,
  input  logic             kbData,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdCode
);
  frameStrobes_t        strobes;
  logic                 fallEdge;
  logic                 gotCode;
  logic [CODE_BITS-1:0] scanCode;

  kbdLineData u_data (
    .clk(clk), .rstN(rstN), .kbClk(kbClk), .kbData(kbData),
    .strobes(strobes), .fallEdge(fallEdge), .gotCode(gotCode), .scanCode(scanCode)
  );

  kbdFrameCtrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .strobes(strobes)
  );

  kbdCmdMap u_map (
    .clk(clk), .rstN(rstN), .gotCode(gotCode), .scanCode(scanCode),
    .cmdValid(cmdValid), .cmdCode(cmdCode)
  );
endmodule

// File: rtl/kbdCmdChecker.sv
module kbdCmdChecker (
  input logic       clk,
  input logic       rstN,
  input logic       gotCode,
  input logic [7:0] scanCode,
  input logic       cmdValid,
  input logic [3:0] cmdCode
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) cmdValid |=> !cmdValid); // R3
  AST_VALID_FROM_FRAME: assert property (@(posedge clk) disable iff (!rstN) cmdValid |-> $past(gotCode)); // R3
  AST_GOT_PULSE: assert property (@(posedge clk) disable iff (!rstN) gotCode |=> !gotCode); // R2
  AST_BREAK_SILENT: assert property (@(posedge clk) disable iff (!rstN) (gotCode && scanCode == 8'hF0) |=> !cmdValid); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN) cmdValid |-> (cmdCode <= 4'd8 || cmdCode == 4'hF)); // R6
endmodule

bind keypadCmdDecoder kbdCmdChecker u_chk (
  .clk(clk), .rstN(rstN), .gotCode(gotCode), .scanCode(scanCode),
  .cmdValid(cmdValid), .cmdCode(cmdCode)
);

// File: tb/sim_keypadCmdDecoder.sv
`timescale 1ns/1ps
module sim_keypadCmdDecoder;
  localparam int TMO  = 150;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kbClk = 1'b1;
  logic kbData = 1'b1;
  logic cmdValid;
  logic [3:0] cmdCode;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  logic [3:0] lastCode = 4'h0;
  logic [2:0] armedModel = 3'b111;

  always #2.5 clk = ~clk;

  keypadCmdDecoder #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rstN(rstN), .kbClk(kbClk), .kbData(kbData),
    .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  always @(negedge clk) begin
    if (cmdValid) begin
      pulseCnt = pulseCnt + 1;
      lastCode = cmdCode;
    end
  end

  function automatic logic [3:0] refCmd(input logic [7:0] sc);
    case (sc)
      8'h6C: return 4'd0;
      8'h75: return 4'd1;
      8'h7D: return 4'd2;
      8'h69: return 4'd3;
      8'h72: return 4'd4;
      8'h7A: return 4'd5;
      8'h70: return 4'd6;
      8'h71: return 4'd7;
      8'h7B: return 4'd8;
      default: return 4'hF;
    endcase
  endfunction

  task automatic driveBit(input logic b);
    @(negedge clk); kbData = b;
    repeat (HALF/2) @(negedge clk);
    kbClk = 1'b0;
    repeat (HALF) @(negedge clk);
    kbClk = 1'b1;
    repeat (HALF/2) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] code, input logic badPar, input logic badStop);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(code[i]);
    driveBit((~^code) ^ badPar);
    driveBit(~badStop);
    kbData = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expectCmd(input string req, input logic [7:0] code, input logic [3:0] exp);
    pulseCnt = 0;
    sendFrame(code, 1'b0, 1'b0);
    checks++;
    if (pulseCnt != 1 || lastCode != exp) begin
      errors++;
      $display("FAIL %s code %02h: pulses %0d cmd %0h, expected 1 pulse cmd %0h", req, code, pulseCnt, lastCode, exp);
    end
  endtask

  task automatic expectSilent(input string req, input logic [7:0] code);
    pulseCnt = 0;
    sendFrame(code, 1'b0, 1'b0);
    checks++;
    if (pulseCnt != 0) begin
      errors++;
      $display("FAIL %s code %02h: pulses %0d, expected 0", req, code, pulseCnt);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (cmdValid !== 1'b0 || cmdCode !== 4'hF) begin
      errors++;
      $display("FAIL R1 reset: valid %b cmd %0h, expected 0 f", cmdValid, cmdCode);
    end
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R4 R5 R6: sweep every code except the release prefix
    for (int c = 0; c < 256; c++) begin
      logic [7:0] sc;
      logic [3:0] e;
      sc = 8'(c);
      if (sc != 8'hF0) begin
        e = refCmd(sc);
        if (e <= 4'd2) begin
          armedModel[e[1:0]] = 1'b0;
          expectCmd("R5", sc, e);
        end else if (e == 4'hF) begin
          expectCmd("R6", sc, e);
        end else begin
          expectCmd("R4", sc, e);
        end
      end
    end

    // R8: a held toggle key stays quiet until released
    expectSilent("R8", 8'h6C);
    expectSilent("R8", 8'h75);
    expectSilent("R7", 8'hF0);
    expectSilent("R7", 8'h6C);
    expectCmd("R8", 8'h6C, 4'd0);
    expectSilent("R8", 8'h75);
    expectSilent("R7", 8'hF0);
    expectSilent("R7", 8'h7D);
    expectCmd("R8", 8'h7D, 4'd2);
    expectSilent("R8", 8'h7D);

    // R9: range keys repeat
    expectCmd("R9", 8'h72, 4'd4);
    expectCmd("R9", 8'h72, 4'd4);
    expectCmd("R9", 8'h7B, 4'd8);

    // R7: flag covers one code only
    expectSilent("R7", 8'hF0);
    expectSilent("R7", 8'h69);
    expectCmd("R7", 8'h72, 4'd4);

    // R2: bad parity and bad stop are ignored
    pulseCnt = 0;
    sendFrame(8'h7A, 1'b1, 1'b1);
    checks++;
    if (pulseCnt != 1 || lastCode != 4'd5) begin
      errors++;
      $display("FAIL R2 parity/stop ignored: pulses %0d cmd %0h, expected 1 pulse cmd 5", pulseCnt, lastCode);
    end

    // R10: stalled partial frame is discarded
    pulseCnt = 0;
    driveBit(1'b0);
    driveBit(1'b1);
    driveBit(1'b0);
    driveBit(1'b1);
    repeat (TMO + 50) @(negedge clk);
    checks++;
    if (pulseCnt != 0) begin
      errors++;
      $display("FAIL R10 partial frame: pulses %0d, expected 0", pulseCnt);
    end
    expectCmd("R10", 8'h70, 4'd6);
    expectCmd("R10", 8'h71, 4'd7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule